// File: doc/BRIEF.md
# Single-Wire Serial Bus Master

This block is a memory-mapped master for a single-wire, open-drain serial link of the HDQ kind. Software places a byte in the transmit register, then writes the control register with the GO bit set. The RECV and BREAK bits in that same write select one of three actions. The first shifts the transmit byte out onto the line. The second collects one byte from the slave into the receive register. The third holds the line low long enough to reset the slave. Every action ends by raising its own flag in a read-to-clear flag register, and by releasing GO (and BREAK).

The line is only ever pulled low, through `line_oe`. The line level comes back on `line_in` and passes through a two-flop synchronizer before the receiver looks at it. All line timing is counted in cycles of `clk` and set by parameters. A soft-reset request returns the control state to its defaults. A status bit shows when that reset has finished. A read-only register gives the major and minor revision.

Top module: `hdq_master`

## Requirements
- R1: After `rst_n` is low on a clock edge, offset 0x00 reads {REV_MAJOR, REV_MINOR} as two nibbles (0x21 by default). Offsets 0x0C and 0x10 read 0x00, offset 0x18 reads 0x01, and `line_oe` and `irq` are low.
- R2: Control byte at 0x0C uses these bits: 6 IRQ_EN, 5 CLK_EN, 4 GO, 2 BREAK, 1 RECV, 0 MODE. Writing GO=1 with BREAK=0 and RECV=0 sends the byte at 0x04 LSB first. Each bit is one T_CELL-cycle cell that starts with a low pulse of T_LOW1 cycles for a 1 or T_LOW0 cycles for a 0. When the byte ends, flag bit 2 at 0x10 is set.
- R3: Writing GO=1 with BREAK=1 drives the line low for exactly T_BREAK cycles, then releases it for T_RECOV cycles. After that, flag bit 0 is set and, with IRQ_EN=1, both GO and BREAK read 0.
- R4: Writing GO=1 with RECV=1 (BREAK=0) receives 8 bits LSB first into 0x08. Each bit starts when the synchronized line goes low, and the bit is its level T_SAMPLE cycles later. The block then sets flag bit 1. A receive can follow a transmit directly.
- R5: During a receive, if the line does not change as expected within RX_TIMEOUT cycles, the receive ends and flag bit 0 is set.
- R6: A read of 0x10 returns the flags and clears all three in the same cycle.
- R7: `irq` is high exactly when IRQ_EN=1 and at least one flag bit is set.
- R8: GO and BREAK are released on completion only when IRQ_EN=1. With IRQ_EN=0 the flag is still set, but GO keeps reading 1.
- R9: While an action runs, writes to 0x0C change only IRQ_EN, CLK_EN and MODE. GO, BREAK and RECV keep their values and no second action starts.
- R10: Writing 1 to bit 1 of 0x14 starts a soft reset. While it runs, 0x18 bit 0 reads 0, any running action stops and the line is released. After SRST_CYCLES cycles, 0x18 bit 0 reads 1. By then 0x04, 0x0C, 0x10 and 0x14 read 0. Bit 0 of 0x14 (auto-idle) is a plain read/write bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; all timing counts use it |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for read-to-clear) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| line_in | input | 1 | Level of the bus wire |
| line_oe | output | 1 | High pulls the bus wire low |

## Verification
Assertions check four things on every cycle. No more than one completion fires in any cycle. A flag read with no completion in the same cycle leaves the flags empty. On completion, GO is released or held according to IRQ_EN. A soft reset leaves GO clear. Only the bench scenarios can show the rest. That covers the exact pulse widths on the wire and the bit order of sent and received bytes. It also covers the receive timeout window, the ignored writes while busy, and the register values after a soft reset. The bench uses a model of the slave and decodes the wire.

// File: rtl/hdq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the single-wire bus master.
// Assumes byte-wide registers at word-aligned byte offsets.
package hdq_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int BIT_W  = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] OFF_REV   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_TXD   = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_RXD   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_FLAGS = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_SCFG  = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_SSTAT = 5'h18;

    localparam int CB_IRQEN = 6;
    localparam int CB_CLKEN = 5;
    localparam int CB_GO    = 4;
    localparam int CB_BRK   = 2;
    localparam int CB_RECV  = 1;
    localparam int CB_MODE  = 0;

    localparam int FB_TX = 2;
    localparam int FB_RX = 1;
    localparam int FB_TO = 0;

    localparam int SC_SRST = 1;
    localparam int SC_IDLE = 0;

    typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} op_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic brk;
        logic to;
    } done_t;
endpackage

// File: rtl/hdq_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for the bus wire level.
// Assumes an idle line reads high, so all stages reset to 1.
module hdq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/hdq_line_engine.sv
`timescale 1ns/1ps
// Line timing engine: runs one break, transmit or receive action per start.
// Assumes start arrives only while idle. Completion strobes are combinational
// and fire in the last busy cycle, so busy and done overlap by one cycle.
module hdq_line_engine
    import hdq_pkg::*;
#(
    parameter int T_BREAK    = 20,
    parameter int T_RECOV    = 10,
    parameter int T_CELL     = 40,
    parameter int T_LOW0     = 28,
    parameter int T_LOW1     = 8,
    parameter int T_SAMPLE   = 20,
    parameter int RX_TIMEOUT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  op_e               op,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              line_s,
    output logic              line_oe,
    output logic              busy,
    output done_t             done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int M1   = (T_CELL > T_BREAK) ? T_CELL : T_BREAK;
    localparam int M2   = (M1 > RX_TIMEOUT) ? M1 : RX_TIMEOUT;
    localparam int M3   = (M2 > T_RECOV) ? M2 : T_RECOV;
    localparam int MAXT = (M3 > T_SAMPLE) ? M3 : T_SAMPLE;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] LIM_BRK  = CNT_W'(T_BREAK - 1);
    localparam logic [CNT_W-1:0] LIM_REC  = CNT_W'(T_RECOV - 1);
    localparam logic [CNT_W-1:0] LIM_CELL = CNT_W'(T_CELL - 1);
    localparam logic [CNT_W-1:0] LIM_SMP  = CNT_W'(T_SAMPLE - 1);
    localparam logic [CNT_W-1:0] LIM_TO   = CNT_W'(RX_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] LEN0     = CNT_W'(T_LOW0);
    localparam logic [CNT_W-1:0] LEN1     = CNT_W'(T_LOW1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_BRK_LOW, S_BRK_REC, S_TX, S_RX_WAIT, S_RX_SAMP, S_RX_REL
    } st_e;

    st_e               st;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  low_len;

    // Low-pulse length of the bit currently on the wire.
    assign low_len = shreg[0] ? LEN1 : LEN0;

    // Sequence the action phases with one shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            st    <= S_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    cnt  <= '0;
                    bitn <= '0;
                    case (op)
                        OP_BRK:  st <= S_BRK_LOW;
                        OP_RX:   begin st <= S_RX_WAIT; shreg <= '0; end
                        default: begin st <= S_TX; shreg <= tx_byte; end
                    endcase
                end
                S_BRK_LOW: if (cnt == LIM_BRK) begin
                    cnt <= '0;
                    st  <= S_BRK_REC;
                end else cnt <= cnt + 1'b1;
                S_BRK_REC: if (cnt == LIM_REC) st <= S_IDLE;
                           else cnt <= cnt + 1'b1;
                S_TX: if (cnt == LIM_CELL) begin
                    cnt   <= '0;
                    shreg <= shreg >> 1;
                    if (bitn == LAST_BIT) st <= S_IDLE;
                    else bitn <= bitn + 1'b1;
                end else cnt <= cnt + 1'b1;
                S_RX_WAIT: if (!line_s) begin
                    st  <= S_RX_SAMP;
                    cnt <= '0;
                end else if (cnt == LIM_TO) st <= S_IDLE;
                else cnt <= cnt + 1'b1;
                S_RX_SAMP: if (cnt == LIM_SMP) begin
                    shreg <= rx_byte;
                    cnt   <= '0;
                    if (bitn == LAST_BIT) st <= S_IDLE;
                    else begin
                        bitn <= bitn + 1'b1;
                        st   <= S_RX_REL;
                    end
                end else cnt <= cnt + 1'b1;
                S_RX_REL: if (line_s) begin
                    st  <= S_RX_WAIT;
                    cnt <= '0;
                end else if (cnt == LIM_TO) st <= S_IDLE;
                else cnt <= cnt + 1'b1;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Decode line drive, busy and the completion strobes from the state.
    always_comb begin
        busy    = (st != S_IDLE);
        line_oe = (st == S_BRK_LOW) || ((st == S_TX) && (cnt < low_len));
        rx_byte = {line_s, shreg[DATA_W-1:1]};
        done.brk = (st == S_BRK_REC) && (cnt == LIM_REC);
        done.tx  = (st == S_TX) && (cnt == LIM_CELL) && (bitn == LAST_BIT);
        done.rx  = (st == S_RX_SAMP) && (cnt == LIM_SMP) && (bitn == LAST_BIT);
        done.to  = (cnt == LIM_TO) &&
                   (((st == S_RX_WAIT) && line_s) || ((st == S_RX_REL) && !line_s));
    end

    a_r2_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done.tx, done.rx, done.brk, done.to}));
endmodule

// File: rtl/hdq_regs.sv
`timescale 1ns/1ps
// Register file: control, data, flags, soft reset and revision.
// Assumes one access per cycle. A read of the flag offset with bus_rd
// high clears the flags at that clock edge.
module hdq_regs
    import hdq_pkg::*;
#(
    parameter int REV_MAJOR   = 2,
    parameter int REV_MINOR   = 1,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_busy,
    input  done_t             done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              start,
    output op_e               op,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq,
    output logic              srst_busy
);
    localparam int SR_W = $clog2(SRST_CYCLES + 1);
    localparam logic [DATA_W-1:0] REV_VAL = DATA_W'((REV_MAJOR << 4) | (REV_MINOR & 15));

    logic irq_en, clk_en, go, brk, recv, mode, auto_idle;
    logic [DATA_W-1:0] rxd;
    logic [2:0]        flags;
    logic [SR_W-1:0]   sr_cnt;
    logic wr_ctrl, rd_flags, done_any;

    assign srst_busy = (sr_cnt != '0);
    assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL) && !srst_busy;
    assign rd_flags  = bus_rd && (bus_addr == OFF_FLAGS);
    assign done_any  = done.tx | done.rx | done.brk | done.to;
    assign start     = wr_ctrl && bus_wdata[CB_GO] && !eng_busy;
    assign op        = bus_wdata[CB_BRK] ? OP_BRK : (bus_wdata[CB_RECV] ? OP_RX : OP_TX);
    assign irq       = irq_en && (flags != '0);

    // Control bits: action bits lock while busy and release on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_busy) begin
            {irq_en, clk_en, go, brk, recv, mode} <= '0;
        end else begin
            if (done_any && irq_en) begin
                go  <= 1'b0;
                brk <= 1'b0;
            end
            if (wr_ctrl) begin
                irq_en <= bus_wdata[CB_IRQEN];
                clk_en <= bus_wdata[CB_CLKEN];
                mode   <= bus_wdata[CB_MODE];
                if (!eng_busy) begin
                    go   <= bus_wdata[CB_GO];
                    brk  <= bus_wdata[CB_BRK];
                    recv <= bus_wdata[CB_RECV];
                end
            end
        end
    end

    // Completion flags: set by the engine, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_busy) flags <= '0;
        else flags <= (rd_flags ? 3'b000 : flags) | {done.tx, done.rx, done.brk | done.to};
    end

    // Transmit and receive data registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_busy) begin
            tx_byte <= '0;
            rxd     <= '0;
        end else begin
            if (bus_wr && (bus_addr == OFF_TXD)) tx_byte <= bus_wdata;
            if (done.rx) rxd <= rx_byte;
        end
    end

    // Soft-reset countdown; a request is taken only when none is running.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_cnt <= '0;
        else if (srst_busy) sr_cnt <= sr_cnt - 1'b1;
        else if (bus_wr && (bus_addr == OFF_SCFG) && bus_wdata[SC_SRST])
            sr_cnt <= SR_W'(SRST_CYCLES);
    end

    // Auto-idle configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_busy) auto_idle <= 1'b0;
        else if (bus_wr && (bus_addr == OFF_SCFG)) auto_idle <= bus_wdata[SC_IDLE];
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_REV:   bus_rdata = REV_VAL;
            OFF_TXD:   bus_rdata = tx_byte;
            OFF_RXD:   bus_rdata = rxd;
            OFF_CTRL:  bus_rdata = {1'b0, irq_en, clk_en, go, 1'b0, brk, recv, mode};
            OFF_FLAGS: bus_rdata = {5'b0, flags};
            OFF_SCFG:  bus_rdata = {6'b0, srst_busy, auto_idle};
            OFF_SSTAT: bus_rdata = {7'b0, !srst_busy};
            default:   bus_rdata = '0;
        endcase
    end

    a_r6_flags_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flags && !done_any |=> flags == 3'b000);
    a_r8_go_released_with_irq_en: assert property (@(posedge clk) disable iff (!rst_n)
        done_any && irq_en && !srst_busy |=> !go && !brk);
    a_r8_go_held_without_irq_en: assert property (@(posedge clk) disable iff (!rst_n)
        done_any && !irq_en && go && !srst_busy |=> go);
    a_r10_srst_clears_action: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> !go && flags == 3'b000);
endmodule

// File: rtl/hdq_master.sv
`timescale 1ns/1ps
// Top of the single-wire bus master: registers, line synchronizer and
// timing engine. Assumes line_in already reflects the open-drain wire.
module hdq_master
    import hdq_pkg::*;
#(
    parameter int REV_MAJOR   = 2,
    parameter int REV_MINOR   = 1,
    parameter int SRST_CYCLES = 4,
    parameter int SYNC_STAGES = 2,
    parameter int T_BREAK     = 20,
    parameter int T_RECOV     = 10,
    parameter int T_CELL      = 40,
    parameter int T_LOW0      = 28,
    parameter int T_LOW1      = 8,
    parameter int T_SAMPLE    = 20,
    parameter int RX_TIMEOUT  = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    input  logic        line_in,
    output logic        line_oe
);
    logic              line_s, eng_busy, start, srst_busy;
    op_e               op;
    done_t             done;
    logic [DATA_W-1:0] tx_byte, rx_byte;

    hdq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(line_in), .q_out(line_s)
    );

    hdq_regs #(
        .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR), .SRST_CYCLES(SRST_CYCLES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .done(done), .rx_byte(rx_byte),
        .start(start), .op(op), .tx_byte(tx_byte), .irq(irq), .srst_busy(srst_busy)
    );

    hdq_line_engine #(
        .T_BREAK(T_BREAK), .T_RECOV(T_RECOV), .T_CELL(T_CELL), .T_LOW0(T_LOW0),
        .T_LOW1(T_LOW1), .T_SAMPLE(T_SAMPLE), .RX_TIMEOUT(RX_TIMEOUT)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .abort(srst_busy), .start(start), .op(op),
        .tx_byte(tx_byte), .line_s(line_s), .line_oe(line_oe), .busy(eng_busy),
        .done(done), .rx_byte(rx_byte)
    );
endmodule

// File: tb/tb_hdq_master.sv
`timescale 1ns/1ps
module tb_hdq_master;
    localparam int T_BREAK = 20, T_LOW0 = 28, T_LOW1 = 8, RX_TIMEOUT = 200;
    localparam logic [4:0] A_REV = 5'h00, A_TXD = 5'h04, A_RXD = 5'h08,
                           A_CTRL = 5'h0C, A_FLG = 5'h10, A_SCFG = 5'h14, A_SST = 5'h18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic irq, line_oe, line_in, slave_low = 1'b0;
    int nchk = 0, nfail = 0, np = 0, run = 0;
    int plen [0:63];
    bit finished = 0;

    hdq_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .line_in(line_in), .line_oe(line_oe)
    );

    always #2.5 clk = ~clk;
    assign line_in = !(line_oe | slave_low);

    // Wire monitor: length of every low pulse driven by the master.
    always @(negedge clk) begin
        if (line_oe) run = run + 1;
        else if (run != 0) begin
            if (np < 64) plen[np] = run;
            np = np + 1;
            run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_irq(input int lim, output int cyc);
        cyc = 0;
        while (!irq && cyc < lim) begin @(negedge clk); cyc++; end
    endtask

    function automatic int exp_len(input logic b);
        return b ? T_LOW1 : T_LOW0;
    endfunction

    function automatic logic [7:0] decode_tx();
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++) v[i] = (plen[i] < (T_LOW0 + T_LOW1) / 2);
        return v;
    endfunction

    task automatic slave_send(input logic [7:0] b);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            slave_low = 1'b1;
            repeat (b[i] ? 8 : 30) @(negedge clk);
            slave_low = 1'b0;
            repeat (b[i] ? 42 : 20) @(negedge clk);
        end
    endtask

    task automatic do_tx(input logic [7:0] b, input string req);
        logic [7:0] v; int c; int bad = 0;
        wr(A_TXD, b);
        np = 0;
        wr(A_CTRL, 8'h70);
        wait_irq(600, c);
        chk({req, " tx irq"}, irq, 1);
        chk({req, " pulse count"}, np, 8);
        chk({req, " byte on wire LSB first"}, decode_tx(), b);
        for (int i = 0; i < 8; i++) if (plen[i] != exp_len(b[i])) bad++;
        chk({req, " pulse widths"}, bad, 0);
        rd(A_CTRL, v); chk({req, " GO released"}, v, 8'h60);
        rd(A_FLG, v);  chk({req, " tx flag"}, v, 8'h04);
    endtask

    task automatic do_rx(input logic [7:0] b, input string req);
        logic [7:0] v; int c;
        wr(A_CTRL, 8'h72);
        slave_send(b);
        wait_irq(100, c);
        rd(A_RXD, v);  chk({req, " received byte"}, v, b);
        rd(A_FLG, v);  chk({req, " rx flag"}, v, 8'h02);
        rd(A_CTRL, v); chk({req, " GO released after rx"}, v, 8'h62);
    endtask

    initial begin
        logic [7:0] v; int c;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_REV, v);  chk("R1 revision", v, 8'h21);
        rd(A_CTRL, v); chk("R1 control", v, 8'h00);
        rd(A_FLG, v);  chk("R1 flags", v, 8'h00);
        rd(A_SST, v);  chk("R1 reset done", v, 8'h01);
        chk("R1 line released", line_oe, 0);
        chk("R1 irq low", irq, 0);
        // R3 break
        wr(A_CTRL, 8'h60);
        np = 0;
        wr(A_CTRL, 8'h74);
        wait_irq(200, c);
        chk("R3 one pulse", np, 1);
        chk("R3 break width", plen[0], T_BREAK);
        chk("R7 irq on flag", irq, 1);
        rd(A_CTRL, v); chk("R3 GO and BREAK cleared", v, 8'h60);
        rd(A_FLG, v);  chk("R3 break flag", v, 8'h01);
        rd(A_FLG, v);  chk("R6 flags cleared by read", v, 8'h00);
        chk("R7 irq drops after read", irq, 0);
        // R2 transmit: directed corners then random bytes
        do_tx(8'h00, "R2");
        do_tx(8'hFF, "R2");
        for (int i = 0; i < 4; i++) do_tx(8'($urandom), "R2");
        // R4 receive: directed corners then random, each right after a transmit
        do_rx(8'h00, "R4");
        do_rx(8'hFF, "R4");
        for (int i = 0; i < 3; i++) begin
            wr(A_CTRL, 8'h60);
            do_tx(8'($urandom), "R4 tx before rx");
            do_rx(8'($urandom), "R4");
        end
        // R5 receive timeout with a silent slave
        wr(A_CTRL, 8'h72);
        wait_irq(400, c);
        chk("R5 timeout window", (c >= RX_TIMEOUT - 2 && c <= RX_TIMEOUT + 5) ? 1 : 0, 1);
        rd(A_FLG, v);  chk("R5 timeout flag", v, 8'h01);
        rd(A_CTRL, v); chk("R5 GO released", v, 8'h62);
        // R8 completion with interrupts disabled
        wr(A_CTRL, 8'h20);
        wr(A_TXD, 8'h3C);
        wr(A_CTRL, 8'h30);
        repeat (400) @(negedge clk);
        chk("R7 irq masked", irq, 0);
        rd(A_CTRL, v); chk("R8 GO held without IRQ_EN", v, 8'h30);
        rd(A_FLG, v);  chk("R8 flag still set", v, 8'h04);
        wr(A_CTRL, 8'h60);
        rd(A_CTRL, v); chk("R8 GO cleared by write", v, 8'h60);
        // R9 writes while busy
        wr(A_TXD, 8'h96);
        np = 0;
        wr(A_CTRL, 8'h70);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 8'h76);
        rd(A_CTRL, v); chk("R9 action bits locked", v, 8'h70);
        wait_irq(600, c);
        chk("R9 no relaunch", np, 8);
        chk("R9 byte unchanged", decode_tx(), 8'h96);
        rd(A_FLG, v); chk("R9 only tx flag", v, 8'h04);
        // R10 soft reset
        wr(A_TXD, 8'hA5);
        wr(A_SCFG, 8'h03);
        rd(A_SST, v);  chk("R10 reset in progress", v, 8'h00);
        repeat (8) @(negedge clk);
        rd(A_SST, v);  chk("R10 reset done", v, 8'h01);
        rd(A_CTRL, v); chk("R10 control default", v, 8'h00);
        rd(A_TXD, v);  chk("R10 tx data default", v, 8'h00);
        rd(A_SCFG, v); chk("R10 config default", v, 8'h00);
        wr(A_SCFG, 8'h01);
        rd(A_SCFG, v); chk("R10 auto-idle bit", v, 8'h01);
        wr(A_CTRL, 8'h60);
        wr(A_TXD, 8'h00);
        wr(A_CTRL, 8'h70);
        repeat (10) @(negedge clk);
        wr(A_SCFG, 8'h02);
        repeat (10) @(negedge clk);
        chk("R10 abort releases line", line_oe, 0);
        rd(A_FLG, v); chk("R10 no flag after abort", v, 8'h00);
        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule